// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block fetches instruction bytes ahead of their use. It holds a code segment value and a 16-bit instruction offset. It forms each 20-bit fetch address by multiplying the segment by sixteen and adding the offset. Each byte that comes back from memory is put into a small first-in first-out queue. A consumer on the execution side takes bytes from the head of that queue whenever it is ready, so fetching and consuming run at the same time.

The memory side is a request/response port. A request is held stable until memory accepts it, and only one fetch is outstanding at any time. Memory answers every accepted request with exactly one data beat, one or more cycles later. A redirect loads a new segment and offset and empties the queue. If a fetch was still in flight when the redirect came, its data is thrown away when it arrives.

Top module: `seg_prefetch_unit`

## Requirements
- R1: The fetch address on `memReqAddr` equals segment × 16 + offset. For example, segment 2500h with offset 95F3h gives 2E5F3h.
- R2: The address sum is kept to 20 bits, and any carry out of bit 19 is dropped. Segment FFFFh with offset 0010h gives 00000h, and with offset 000Fh gives FFFFFh.
- R3: After reset the segment is FFFFh, the offset is 0000h and the queue is empty. The first request therefore asks for FFFF0h while `popValid` is low.
- R4: Each byte written into the queue advances the offset by one, modulo 2^16, and leaves the segment unchanged. Offset FFFFh in segment 2500h fetches 34FFFh, and the next fetch is 25000h.
- R5: The queue holds 6 bytes and returns them in fetch order. While it holds 6 bytes, `memReqValid` stays low.
- R6: At most one fetch is outstanding. An unaccepted request keeps `memReqValid` high with `memReqAddr` unchanged until `memReqReady` is seen, unless a redirect occurs.
- R7: `popValid` is high exactly when the queue is not empty, and `popData` shows the oldest byte. A pop asserted while the queue is empty has no effect.
- R8: A redirect loads the new segment and offset and empties the queue. The next request is sent to the new address.
- R9: The response to a fetch that was in flight during a redirect is dropped, and so is a response that arrives in the redirect cycle itself. The queue and the offset stay unchanged when it is dropped.
- R10: A pop and a byte arrival in the same cycle both take effect.
- R11: A redirect has priority: no request is offered in the redirect cycle, and a pop in that cycle has no effect beyond the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redirectValid | input | 1 | Load new segment/offset and flush |
| redirectSeg | input | 16 | New code segment value |
| redirectOff | input | 16 | New instruction offset |
| memReqValid | output | 1 | Fetch request offered |
| memReqAddr | output | 20 | Physical fetch address |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memRspValid | input | 1 | Fetch data returned this cycle |
| memRspData | input | 8 | Returned instruction byte |
| popValid | output | 1 | Queue head holds a byte |
| popData | output | 8 | Oldest queued byte |
| popReady | input | 1 | Consumer takes the head byte |

## Verification
A wrong offset or segment shows up on `memReqAddr` in the next request. When memory is always ready, that request comes one cycle after the previous byte arrives. A broken queue pointer or count shows as a wrong `popData` value or a wrong `popValid` level on the next pop, since the bench compares every cycle against a behavioural queue. A lost drop flag shows up soon after a redirect: a stale byte appears at the queue head, and the next fetch address is off by one. The wrap cases at FFFFh offset and at the top of the 1 MB space are driven directly, so a carry error shows on the first affected request.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // Strobes from control to datapath, one per datapath action in a cycle
  typedef struct packed {
    logic loadRedirect;  // load segment/offset, empty the queue
    logic pushByte;      // write returned byte, advance offset
    logic popByte;       // remove head byte
    logic issueReq;      // request handed to memory this cycle
  } pfqStrobes_t;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        redirectValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        popReady,
  input  logic        queueEmpty,
  input  logic        queueFull,
  output logic        memReqValid,
  output pfqStrobes_t strobes
);
  logic inFlight;   // one fetch accepted, data not yet back
  logic dropNext;   // that fetch belongs to a flushed stream
  logic wantFetch;

  assign wantFetch   = !inFlight && !queueFull && !redirectValid;
  assign memReqValid = wantFetch;

  always_comb begin
    strobes              = '0;
    strobes.loadRedirect = redirectValid;
    strobes.pushByte     = memRspValid && inFlight && !dropNext && !redirectValid;
    strobes.popByte      = popReady && !queueEmpty && !redirectValid;
    strobes.issueReq     = wantFetch && memReqReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      dropNext <= 1'b0;
    end else if (memRspValid && inFlight) begin
      inFlight <= 1'b0;
      dropNext <= 1'b0;
    end else begin
      if (strobes.issueReq) inFlight <= 1'b1;
      if (redirectValid && inFlight) dropNext <= 1'b1;
    end
  end

  // R9: a pending drop always refers to a fetch still in flight
  p_drop_needs_flight_r9: assert property (@(posedge clk) disable iff (!rstN)
    dropNext |-> inFlight);

  // R6: an offered but unaccepted request is still offered next cycle
  p_req_persists_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !redirectValid) |=> (memReqValid || redirectValid));

  // R6: a new request never appears while data is still owed
  p_no_second_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issueReq) |=> !memReqValid);
endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int SEG_W       = 16,
  parameter int OFF_W       = 16,
  parameter int SEG_SHIFT   = 4,
  parameter int DATA_W      = 8,
  parameter int QUEUE_DEPTH = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFF_W-1:0] RESET_OFF = '0,
  localparam int ADDR_W = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfqStrobes_t       strobes,
  input  logic [SEG_W-1:0]  redirectSeg,
  input  logic [OFF_W-1:0]  redirectOff,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              queueEmpty,
  output logic              queueFull,
  output logic [DATA_W-1:0] headData
);
  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  logic [SEG_W-1:0]  codeSeg;
  logic [OFF_W-1:0]  instOff;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fillCount;
  logic [DATA_W-1:0] slot [QUEUE_DEPTH];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Segment times sixteen plus offset, kept to ADDR_W bits
  assign fetchAddr  = {codeSeg, {SEG_SHIFT{1'b0}}} + ADDR_W'(instOff);
  assign queueEmpty = (fillCount == '0);
  assign queueFull  = (fillCount == CNT_W'(QUEUE_DEPTH));
  assign headData   = slot[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeSeg <= RESET_SEG;
      instOff <= RESET_OFF;
    end else if (strobes.loadRedirect) begin
      codeSeg <= redirectSeg;
      instOff <= redirectOff;
    end else if (strobes.pushByte) begin
      instOff <= instOff + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.loadRedirect) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (strobes.pushByte) wrPtr <= nextPtr(wrPtr);
      if (strobes.popByte)  rdPtr <= nextPtr(rdPtr);
      unique case ({strobes.pushByte, strobes.popByte})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  for (genvar s = 0; s < QUEUE_DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.pushByte && wrPtr == PTR_W'(s)) slot[s] <= memRspData;
    end
  end

  // R5: occupancy never exceeds the queue size
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(QUEUE_DEPTH));

  // R7: an empty queue stays empty unless a byte arrives
  p_empty_pop_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (queueEmpty && !strobes.pushByte) |=> queueEmpty);

  // R4: the segment only moves on a redirect
  p_seg_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadRedirect) |=> $stable(codeSeg));
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit
  import pfq_pkg::*;
#(
  parameter int SEG_W       = 16,
  parameter int OFF_W       = 16,
  parameter int SEG_SHIFT   = 4,
  parameter int DATA_W      = 8,
  parameter int QUEUE_DEPTH = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFF_W-1:0] RESET_OFF = '0,
  localparam int ADDR_W = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redirectValid,
  input  logic [SEG_W-1:0]  redirectSeg,
  input  logic [OFF_W-1:0]  redirectOff,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  input  logic              popReady
);
  pfqStrobes_t strobes;
  logic        queueEmpty;
  logic        queueFull;

  pfq_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .redirectValid (redirectValid),
    .memReqReady   (memReqReady),
    .memRspValid   (memRspValid),
    .popReady      (popReady),
    .queueEmpty    (queueEmpty),
    .queueFull     (queueFull),
    .memReqValid   (memReqValid),
    .strobes       (strobes)
  );

  pfq_datapath #(
    .SEG_W       (SEG_W),
    .OFF_W       (OFF_W),
    .SEG_SHIFT   (SEG_SHIFT),
    .DATA_W      (DATA_W),
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .RESET_SEG   (RESET_SEG),
    .RESET_OFF   (RESET_OFF)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .redirectSeg (redirectSeg),
    .redirectOff (redirectOff),
    .memRspData  (memRspData),
    .fetchAddr   (memReqAddr),
    .queueEmpty  (queueEmpty),
    .queueFull   (queueFull),
    .headData    (popData)
  );

  assign popValid = !queueEmpty;

  // R6: a waiting request keeps its address
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !redirectValid) |=> (redirectValid || $stable(memReqAddr)));

  // R8: the queue is empty right after a redirect
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !popValid);

  // R11: no request is offered during a redirect
  p_redirect_blocks_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> !memReqValid);
endmodule

// File: tb/tb_seg_prefetch_unit.sv
module tb_seg_prefetch_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        redirectValid;
  logic [15:0] redirectSeg, redirectOff;
  logic        memReqValid;
  logic [19:0] memReqAddr;
  logic        memReqReady;
  logic        memRspValid;
  logic [7:0]  memRspData;
  logic        popValid;
  logic [7:0]  popData;
  logic        popReady;

  seg_prefetch_unit dut (
    .clk(clk), .rstN(rstN),
    .redirectValid(redirectValid), .redirectSeg(redirectSeg), .redirectOff(redirectOff),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .popValid(popValid), .popData(popData), .popReady(popReady)
  );

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string tag = "R3";

  // Behavioural reference state
  logic [15:0] mSeg = 16'hFFFF;
  logic [15:0] mIp = 16'h0000;
  logic [7:0]  mQ[$];
  bit          mOut = 0;
  bit          mDisc = 0;

  // Memory environment
  int         rspTimer = 0;
  logic [7:0] rspByte = 8'h00;

  // Last sampled outputs
  logic        lastReqValid, lastPopValid;
  logic [19:0] lastReqAddr;
  logic [7:0]  lastPopData;

  function automatic logic [7:0] memFn(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ {4'h0, a[11:8]} ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit redir, input logic [15:0] rs, input logic [15:0] ro,
                      input bit pop, input bit rdy, input int lat);
    bit          eV;
    logic [19:0] eA;
    bit          rsp;
    @(negedge clk);
    redirectValid = redir;
    redirectSeg   = rs;
    redirectOff   = ro;
    popReady      = pop;
    memReqReady   = rdy;
    memRspValid   = (rspTimer == 1);
    memRspData    = rspByte;
    #1;
    eV = !mOut && (mQ.size() < 6) && !redir;
    eA = {mSeg, 4'h0} + {4'h0, mIp};
    check(memReqValid == eV, tag, 32'(memReqValid), 32'(eV));
    if (eV) check(memReqAddr == eA, tag, 32'(memReqAddr), 32'(eA));
    check(popValid == (mQ.size() != 0), tag, 32'(popValid), 32'(mQ.size() != 0));
    if (mQ.size() != 0) check(popData == mQ[0], tag, 32'(popData), 32'(mQ[0]));
    lastReqValid = memReqValid;
    lastReqAddr  = memReqAddr;
    lastPopValid = popValid;
    lastPopData  = popData;
    rsp = memRspValid;
    if (redir) begin
      mQ.delete();
      mSeg = rs;
      mIp  = ro;
      if (mOut) begin
        if (rsp) begin mOut = 0; mDisc = 0; end
        else mDisc = 1;
      end
    end else begin
      if (pop && mQ.size() > 0) void'(mQ.pop_front());
      if (rsp && mOut) begin
        if (mDisc) mDisc = 0;
        else begin mQ.push_back(memRspData); mIp = mIp + 16'd1; end
        mOut = 0;
      end
      if (eV && rdy) mOut = 1;
    end
    if (rspTimer > 0) rspTimer--;
    if (memReqValid && rdy) begin
      rspTimer = lat;
      rspByte  = memFn(memReqAddr);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    lf = 32'hACE1_1234;
    rstN = 1'b0; redirectValid = 0; redirectSeg = 0; redirectOff = 0;
    memReqReady = 0; memRspValid = 0; memRspData = 0; popReady = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R3: reset state
    tag = "R3";
    step(0, 0, 0, 0, 0, 1);
    check(lastReqValid == 1'b1, "R3", 32'(lastReqValid), 1);
    check(lastReqAddr == 20'hFFFF0, "R3", 32'(lastReqAddr), 32'hFFFF0);
    check(lastPopValid == 1'b0, "R3", 32'(lastPopValid), 0);

    // R1: worked example
    tag = "R1";
    step(1, 16'h2500, 16'h95F3, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    check(lastReqAddr == 20'h2E5F3, "R1", 32'(lastReqAddr), 32'h2E5F3);

    // R5: fill to six bytes, fetching stops
    tag = "R5";
    for (int i = 0; i < 40 && mQ.size() != 6; i++) step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 1);
    check(lastReqValid == 1'b0, "R5", 32'(lastReqValid), 0);
    check(lastPopValid == 1'b1, "R5", 32'(lastPopValid), 1);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 1, 0, 1);
      check(lastPopData == memFn(20'h2E5F3 + 20'(i)), "R5", 32'(lastPopData), 32'(memFn(20'h2E5F3 + 20'(i))));
    end

    // R7: pop on empty queue ignored
    tag = "R7";
    step(0, 0, 0, 1, 0, 1);
    check(lastPopValid == 1'b0, "R7", 32'(lastPopValid), 0);
    step(0, 0, 0, 0, 0, 1);
    check(lastPopValid == 1'b0, "R7", 32'(lastPopValid), 0);
    check(lastReqAddr == 20'h2E5F9, "R4", 32'(lastReqAddr), 32'h2E5F9);

    // R2: 1 MB wrap
    tag = "R2";
    step(1, 16'hFFFF, 16'h0010, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    check(lastReqAddr == 20'h00000, "R2", 32'(lastReqAddr), 0);
    step(1, 16'hFFFF, 16'h000F, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    check(lastReqAddr == 20'hFFFFF, "R2", 32'(lastReqAddr), 32'hFFFFF);

    // R11: redirect blocks request; R4: offset wrap in segment
    tag = "R11";
    step(1, 16'h2500, 16'hFFFF, 1, 1, 1);
    check(lastReqValid == 1'b0, "R11", 32'(lastReqValid), 0);
    tag = "R4";
    for (int i = 0; i < 20 && mQ.size() != 2; i++) step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0, 1);
    check(lastPopData == memFn(20'h34FFF), "R4", 32'(lastPopData), 32'(memFn(20'h34FFF)));
    step(0, 0, 0, 1, 0, 1);
    check(lastPopData == memFn(20'h25000), "R4", 32'(lastPopData), 32'(memFn(20'h25000)));

    // R9 and R8: flush with a fetch in flight
    tag = "R9";
    step(1, 16'h1000, 16'h0000, 0, 0, 1);
    step(0, 0, 0, 0, 1, 3);
    step(1, 16'h3000, 16'h0000, 0, 0, 1);
    for (int i = 0; i < 30 && !lastPopValid; i++) step(0, 0, 0, 0, 1, 1);
    check(lastPopData == memFn(20'h30000), "R9", 32'(lastPopData), 32'(memFn(20'h30000)));
    tag = "R8";
    step(1, 16'h4000, 16'h0100, 1, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    check(lastPopValid == 1'b0, "R8", 32'(lastPopValid), 0);
    check(lastReqAddr == 20'h40100, "R8", 32'(lastReqAddr), 32'h40100);

    // R6, R10, R11 and R9 under mixed traffic
    tag = "R6 R10 R11 R9 mixed";
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[9:5] == 5'd0, lf[31:16], lf[23:8], lf[2], lf[3] | lf[4], 1 + int'(lf[7:6] % 3));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule